// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler with Self-Refresh

This block keeps an asynchronous DRAM's contents alive by issuing CAS-before-RAS refresh cycles spread evenly across the retention window. A free-running interval counter adds one owed refresh every `INTERVAL_CYC` clocks, up to a saturating limit. While anything is owed, the block asks the main memory controller for the strobe bus. Once granted, it drives one refresh cycle directly on the RAS, lower/upper CAS and write-enable pins. It holds the bus through the RAS precharge time and then hands the bus back.

The block also puts the device into its low-power self-refresh state and brings it out again. A sleep request runs a CBR cycle and keeps RAS low for the minimum self-refresh hold time. The strobes then stay low until a wake request arrives. On wake, all strobes are raised and held high for the exit recovery time. If the system uses burst-style refresh (`BURST_STYLE=1`), a catch-up burst of `BURST_LEN` CBR cycles follows at minimum spacing. With distributed refresh (`BURST_STYLE=0`), the bus is released straight away and the interval schedule restarts from zero.

The bus handshake follows valid/ready rules. `rfsh_req` is the valid side. Once raised, it stays high until the block has finished its whole sequence, including precharge. `rfsh_gnt` is the ready side. The block does nothing with the strobes until it samples the grant high. After that, the controller must keep the grant high for as long as the request stays high, and may withdraw it once the request falls. Withholding the grant is back-pressure: the owed count builds up, up to its cap, and no refresh is lost below that cap.

Top module: `rfsh_sched`

## Requirements
- R1: One refresh becomes owed every `INTERVAL_CYC` clocks after reset. While any refresh is owed and the block is idle, it raises `rfsh_req`. Each grant serves exactly one owed refresh.
- R2: The owed count saturates at `OWED_MAX`. After a long period without grant, exactly `OWED_MAX` refresh cycles run back to back once the grant returns.
- R3: The handshake rules are as follows. `rfsh_req` stays high from request to end of sequence. No strobe goes low before the grant is sampled. While `rfsh_req` is low, `ras_n`, `casl_n` and `cash_n` are all high.
- R4: In every refresh cycle, `casl_n` and `cash_n` fall together while `ras_n` is high, exactly `CAS_LEAD` clocks before `ras_n` falls. `we_n` is high at all times.
- R5: In a normal refresh, `ras_n` stays low for exactly `RAS_LOW` clocks, and both CAS strobes rise in the same clock as `ras_n`.
- R6: After each refresh, all strobes stay high for at least `RAS_PRE` clocks before the next CAS fall. `rfsh_req` falls exactly `RAS_PRE` clocks after RAS rises.
- R7: A `sleep_enter` pulse sampled while idle runs a CBR cycle whose RAS-low phase lasts `SR_HOLD` clocks, and only then raises `asleep`. While `asleep` is high, all strobes stay low and no further refresh cycle occurs. `sleep_enter` takes priority over owed refreshes.
- R8: A `sleep_exit` pulse while asleep drops `asleep` and raises all strobes. They stay high for exactly `SR_EXIT` clocks before any further strobe activity or release of the bus.
- R9: With `BURST_STYLE=1`, exit is followed by `BURST_LEN` CBR cycles spaced by exactly `RAS_PRE` precharge clocks. The request then falls `BURST_LEN*(CAS_LEAD+RAS_LOW+RAS_PRE)` clocks after the exit recovery ends. With `BURST_STYLE=0`, no refresh follows the exit and the request falls as the recovery ends.
- R10: Owed refreshes are discarded during a self-refresh sequence. The interval restarts at bus release, so the next CAS fall comes exactly `INTERVAL_CYC+2` clocks after `rfsh_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_enter | input | 1 | Request to enter self-refresh, sampled while idle |
| sleep_exit | input | 1 | Request to leave self-refresh, sampled while asleep |
| rfsh_gnt | input | 1 | Bus grant from the main controller (ready) |
| rfsh_req | output | 1 | Bus request to the main controller (valid) |
| asleep | output | 1 | High while the device is held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower-byte column strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
The bench goes after the saturation boundary by withholding the grant for six intervals. A counter that wraps or does not cap would then run the wrong number of back-to-back cycles. It times the wake path on a burst-style and a distributed-style instance at once. A missing or extra catch-up burst, a short exit recovery, or an interval that is not restarted at release each moves a measured clock count. Randomly delayed grants check that no strobe moves ahead of the grant and that no refresh is dropped or duplicated. Throughout the run, a monitor times every CAS lead, RAS low phase and precharge gap, so a CAS falling after RAS or a precharge cut short is caught.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_RASLO,
    ST_PRE,
    ST_SLEEP,
    ST_EXIT
  } rf_state_e;

  typedef enum logic [1:0] {
    MD_REF,
    MD_SLEEP,
    MD_BURST
  } rf_mode_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int INTERVAL_CYC = 1560,
  parameter int OWED_MAX     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic take,
  output logic owed_nz
);
  localparam int CW = $clog2(INTERVAL_CYC);
  localparam int OW = $clog2(OWED_MAX + 1);

  logic [CW-1:0] cnt;
  logic [OW-1:0] owed;
  logic          tick;

  assign tick    = (cnt == CW'(INTERVAL_CYC - 1));
  assign owed_nz = (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      owed <= '0;
    end else if (hold) begin
      cnt  <= '0;
      owed <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      case ({tick, take})
        2'b10: if (owed != OW'(OWED_MAX)) owed <= owed + 1'b1;
        2'b01: if (owed != '0) owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  a_r2_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX));

  a_r1_tick_makes_owed: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !take) |=> owed_nz);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int CAS_LEAD    = 2,
  parameter int RAS_LOW     = 5,
  parameter int RAS_PRE     = 4,
  parameter int SR_HOLD     = 10000,
  parameter int SR_EXIT     = 11,
  parameter int BURST_LEN   = 4096,
  parameter bit BURST_STYLE = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      owed_nz,
  input  logic      sleep_enter,
  input  logic      sleep_exit,
  input  logic      gnt,
  output logic      req,
  output logic      take,
  output logic      hold,
  output logic      asleep,
  output rf_state_e state
);
  localparam int TMAX = max2(max2(CAS_LEAD, RAS_LOW), max2(max2(RAS_PRE, SR_HOLD), SR_EXIT));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(BURST_LEN + 1);

  rf_state_e st, st_n;
  rf_mode_e  md, md_n;
  logic [TW-1:0] tmr, tmr_n;
  logic [BW-1:0] bl, bl_n;
  logic          exit_burst;

  generate
    if (BURST_STYLE) begin : g_burst
      assign exit_burst = 1'b1;
    end else begin : g_dist
      assign exit_burst = 1'b0;
    end
  endgenerate

  always_comb begin
    st_n  = st;
    md_n  = md;
    tmr_n = tmr + 1'b1;
    bl_n  = bl;
    take  = 1'b0;
    case (st)
      ST_IDLE: begin
        tmr_n = '0;
        if (sleep_enter) begin
          st_n = ST_WAIT;
          md_n = MD_SLEEP;
        end else if (owed_nz) begin
          st_n = ST_WAIT;
          md_n = MD_REF;
        end
      end
      ST_WAIT: begin
        tmr_n = '0;
        if (gnt) begin
          st_n = ST_LEAD;
          take = (md == MD_REF);
        end
      end
      ST_LEAD: begin
        if (tmr == TW'(CAS_LEAD - 1)) begin
          st_n  = ST_RASLO;
          tmr_n = '0;
        end
      end
      ST_RASLO: begin
        if (md == MD_SLEEP) begin
          if (tmr == TW'(SR_HOLD - 1)) begin
            st_n  = ST_SLEEP;
            tmr_n = '0;
          end
        end else if (tmr == TW'(RAS_LOW - 1)) begin
          st_n  = ST_PRE;
          tmr_n = '0;
        end
      end
      ST_PRE: begin
        if (tmr == TW'(RAS_PRE - 1)) begin
          tmr_n = '0;
          if (md == MD_BURST && bl != '0) begin
            st_n = ST_LEAD;
            bl_n = bl - 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_SLEEP: begin
        tmr_n = '0;
        if (sleep_exit) st_n = ST_EXIT;
      end
      ST_EXIT: begin
        if (tmr == TW'(SR_EXIT - 1)) begin
          tmr_n = '0;
          if (exit_burst) begin
            st_n = ST_LEAD;
            md_n = MD_BURST;
            bl_n = BW'(BURST_LEN - 1);
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: begin
        st_n  = ST_IDLE;
        tmr_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      md  <= MD_REF;
      tmr <= '0;
      bl  <= '0;
    end else begin
      st  <= st_n;
      md  <= md_n;
      tmr <= tmr_n;
      bl  <= bl_n;
    end
  end

  assign req    = (st != ST_IDLE);
  assign hold   = (st != ST_IDLE) && (md != MD_REF);
  assign asleep = (st == ST_SLEEP);
  assign state  = st;

  a_r6_release_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(st == ST_PRE || st == ST_EXIT));

  a_r7_sleep_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(st == ST_RASLO && md == MD_SLEEP));

  a_r3_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !gnt) |=> st == ST_WAIT);
endmodule

// File: rtl/rfsh_strobe.sv
module rfsh_strobe
  import rfsh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rf_state_e state,
  output logic      ras_n,
  output logic      casl_n,
  output logic      cash_n,
  output logic      we_n
);
  logic cas_low;

  assign cas_low = (state == ST_LEAD) || (state == ST_RASLO) || (state == ST_SLEEP);
  assign ras_n   = !((state == ST_RASLO) || (state == ST_SLEEP));
  assign casl_n  = !cas_low;
  assign cash_n  = !cas_low;
  assign we_n    = 1'b1;

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!casl_n && !cash_n && $past(!casl_n)));

  a_r5_cas_rises_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (casl_n && cash_n));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int INTERVAL_CYC = 1560,
  parameter int OWED_MAX     = 8,
  parameter int CAS_LEAD     = 2,
  parameter int RAS_LOW      = 5,
  parameter int RAS_PRE      = 4,
  parameter int SR_HOLD      = 10000,
  parameter int SR_EXIT      = 11,
  parameter int BURST_LEN    = 4096,
  parameter bit BURST_STYLE  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_enter,
  input  logic sleep_exit,
  input  logic rfsh_gnt,
  output logic rfsh_req,
  output logic asleep,
  output logic ras_n,
  output logic casl_n,
  output logic cash_n,
  output logic we_n
);
  logic      owed_nz, take, hold;
  rf_state_e state;

  rfsh_interval #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .OWED_MAX    (OWED_MAX)
  ) u_interval (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .take   (take),
    .owed_nz(owed_nz)
  );

  rfsh_seq #(
    .CAS_LEAD   (CAS_LEAD),
    .RAS_LOW    (RAS_LOW),
    .RAS_PRE    (RAS_PRE),
    .SR_HOLD    (SR_HOLD),
    .SR_EXIT    (SR_EXIT),
    .BURST_LEN  (BURST_LEN),
    .BURST_STYLE(BURST_STYLE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .owed_nz    (owed_nz),
    .sleep_enter(sleep_enter),
    .sleep_exit (sleep_exit),
    .gnt        (rfsh_gnt),
    .req        (rfsh_req),
    .take       (take),
    .hold       (hold),
    .asleep     (asleep),
    .state      (state)
  );

  rfsh_strobe u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .ras_n (ras_n),
    .casl_n(casl_n),
    .cash_n(cash_n),
    .we_n  (we_n)
  );

  a_r3_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_req |-> (ras_n && casl_n && cash_n));

  a_r3_cas_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(casl_n) |-> $past(rfsh_gnt));

  a_r7_asleep_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!ras_n && !casl_n && !cash_n));

  a_r8_wake_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (ras_n && casl_n && cash_n && rfsh_req));
endmodule

// File: tb/rfsh_sched_test.sv
module rfsh_mon #(
  parameter int CAS_LEAD = 2,
  parameter int RAS_LOW  = 4,
  parameter int RAS_PRE  = 3,
  parameter int SR_HOLD  = 12,
  parameter int SR_EXIT  = 6
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ras_n,
  input logic casl_n,
  input logic cash_n,
  input logic we_n,
  input logic asleep
);
  int errs = 0, checks = 0, cbr = 0;
  int hi_run = 0, lo_run = 0, lead_run = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %m %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      hi_run = 0; lo_run = 0; lead_run = 0;
      p_ras = 1'b1; p_cas = 1'b1; p_req = 1'b0;
    end else begin
      chk(we_n == 1'b1, "R4 we_n held high", int'(we_n), 1);
      chk(casl_n == cash_n, "R4 CAS strobes together", int'(cash_n), int'(casl_n));
      if (!req) chk(ras_n && casl_n, "R3 idle strobes high", int'({ras_n, casl_n}), 3);
      if (asleep) chk(!ras_n && !casl_n, "R7 asleep strobes low", int'({ras_n, casl_n}), 0);
      if (p_ras && !ras_n) begin
        chk(!casl_n, "R4 CAS low at RAS fall", int'(casl_n), 0);
        chk(lead_run == CAS_LEAD, "R4 CAS lead", lead_run, CAS_LEAD);
        cbr++;
      end
      if (!p_ras && ras_n) begin
        chk(casl_n, "R5 CAS rises with RAS", int'(casl_n), 1);
        if (lo_run < SR_HOLD) chk(lo_run == RAS_LOW, "R5 RAS low time", lo_run, RAS_LOW);
      end
      if (p_cas && !casl_n) chk(hi_run >= RAS_PRE, "R6 precharge gap", hi_run, RAS_PRE);
      if (p_req && !req)
        chk(hi_run == RAS_PRE || hi_run == SR_EXIT, "R6 release timing", hi_run, RAS_PRE);
      hi_run   = (ras_n && casl_n) ? hi_run + 1 : 0;
      lo_run   = (!ras_n) ? lo_run + 1 : 0;
      lead_run = (!casl_n && ras_n) ? lead_run + 1 : 0;
      p_ras = ras_n; p_cas = casl_n; p_req = req;
    end
  end
endmodule

module rfsh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 200;
  localparam int OWED_MAX   = 4;
  localparam int CAS_LEAD   = 2;
  localparam int RAS_LOW    = 4;
  localparam int RAS_PRE    = 3;
  localparam int SR_HOLD    = 12;
  localparam int SR_EXIT    = 6;
  localparam int BURST_LEN  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_enter = 1'b0, sleep_exit = 1'b0;
  logic gnt_a = 1'b0, gnt_b = 1'b0;
  logic req_a, asl_a, ras_a, casl_a, cash_a, we_a;
  logic req_b, asl_b, ras_b, casl_b, cash_b, we_b;
  logic gnt_en = 1'b1, gnt_rand = 1'b0;
  int cyc = 0;
  int t_err = 0, t_chk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_sched #(.INTERVAL_CYC(INTERVAL), .OWED_MAX(OWED_MAX), .CAS_LEAD(CAS_LEAD),
    .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE), .SR_HOLD(SR_HOLD), .SR_EXIT(SR_EXIT),
    .BURST_LEN(BURST_LEN), .BURST_STYLE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
    .rfsh_gnt(gnt_a), .rfsh_req(req_a), .asleep(asl_a), .ras_n(ras_a),
    .casl_n(casl_a), .cash_n(cash_a), .we_n(we_a));

  rfsh_sched #(.INTERVAL_CYC(INTERVAL), .OWED_MAX(OWED_MAX), .CAS_LEAD(CAS_LEAD),
    .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE), .SR_HOLD(SR_HOLD), .SR_EXIT(SR_EXIT),
    .BURST_LEN(BURST_LEN), .BURST_STYLE(1'b0)) uut_dist (
    .clk(clk), .rst_n(rst_n), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
    .rfsh_gnt(gnt_b), .rfsh_req(req_b), .asleep(asl_b), .ras_n(ras_b),
    .casl_n(casl_b), .cash_n(cash_b), .we_n(we_b));

  rfsh_mon #(.CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE),
    .SR_HOLD(SR_HOLD), .SR_EXIT(SR_EXIT)) mon_a (
    .clk(clk), .rst_n(rst_n), .req(req_a), .ras_n(ras_a), .casl_n(casl_a),
    .cash_n(cash_a), .we_n(we_a), .asleep(asl_a));

  rfsh_mon #(.CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE),
    .SR_HOLD(SR_HOLD), .SR_EXIT(SR_EXIT)) mon_b (
    .clk(clk), .rst_n(rst_n), .req(req_b), .ras_n(ras_b), .casl_n(casl_b),
    .cash_n(cash_b), .we_n(we_b), .asleep(asl_b));

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // Grant model: once given, held until the request drops.
  always @(negedge clk) begin
    if (!req_a) gnt_a <= 1'b0;
    else if (gnt_a || (gnt_en && (!gnt_rand || ($urandom % 4) != 0))) gnt_a <= 1'b1;
    if (!req_b) gnt_b <= 1'b0;
    else if (gnt_b || (gnt_en && (!gnt_rand || ($urandom % 4) != 0))) gnt_b <= 1'b1;
  end

  function automatic int burst_release(input int n);
    return n * (CAS_LEAD + RAS_LOW + RAS_PRE);
  endfunction

  function automatic int resume_gap(input int ivl);
    return ivl + 2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    t_chk++;
    if (!ok) begin
      t_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input int ph);
    @(negedge clk);
    while ((cyc % INTERVAL) != ph) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks",
             t_err + mon_a.errs + mon_b.errs, t_chk + mon_a.checks + mon_b.checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    t_chk++; t_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int base_a, base_b, k, k2, t_rel;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(req_a == 1'b0 && req_b == 1'b0, "R3 reset request low", int'({req_a, req_b}), 0);
    check(ras_a && casl_a && cash_a && ras_b && casl_b && cash_b, "R3 reset strobes high",
          int'({ras_a, casl_a, cash_a}), 7);
    check(!asl_a && !asl_b, "R7 reset not asleep", int'({asl_a, asl_b}), 0);
    rst_n = 1'b1;

    // R1: distributed schedule over five intervals
    while (cyc != 5 * INTERVAL + 20) @(negedge clk);
    check(mon_a.cbr == 5, "R1 refresh count burst-style inst", mon_a.cbr, 5);
    check(mon_b.cbr == 5, "R1 refresh count distributed inst", mon_b.cbr, 5);

    // R1/R3: random grant delays over ten intervals
    wait_phase(100);
    base_a = mon_a.cbr; base_b = mon_b.cbr;
    gnt_rand = 1'b1;
    repeat (10 * INTERVAL) @(negedge clk);
    gnt_rand = 1'b0;
    check(mon_a.cbr - base_a == 10, "R1 random grant count a", mon_a.cbr - base_a, 10);
    check(mon_b.cbr - base_b == 10, "R1 random grant count b", mon_b.cbr - base_b, 10);

    // R2: withhold grant for six ticks, then drain
    wait_phase(20);
    gnt_en = 1'b0;
    repeat (6 * INTERVAL) @(negedge clk);
    check(req_a == 1'b1, "R3 request held while ungranted", int'(req_a), 1);
    check(ras_a && casl_a, "R3 no strobes without grant", int'({ras_a, casl_a}), 3);
    base_a = mon_a.cbr; base_b = mon_b.cbr;
    gnt_en = 1'b1;
    repeat (100) @(negedge clk);
    check(mon_a.cbr - base_a == OWED_MAX, "R2 capped drain a", mon_a.cbr - base_a, OWED_MAX);
    check(mon_b.cbr - base_b == OWED_MAX, "R2 capped drain b", mon_b.cbr - base_b, OWED_MAX);

    // R7: self-refresh entry
    wait_phase(60);
    base_a = mon_a.cbr; base_b = mon_b.cbr;
    sleep_enter = 1'b1;
    @(negedge clk);
    sleep_enter = 1'b0;
    repeat (30) @(negedge clk);
    check(asl_a && asl_b, "R7 asleep after entry", int'({asl_a, asl_b}), 3);
    check(mon_a.cbr - base_a == 1, "R7 entry is one CBR", mon_a.cbr - base_a, 1);
    repeat (1000) @(negedge clk);
    check(mon_a.cbr - base_a == 1 && mon_b.cbr - base_b == 1, "R7 no refresh while asleep",
          mon_b.cbr - base_b, 1);
    check(!ras_a && !casl_a && req_a, "R7 strobes held low", int'({ras_a, casl_a, req_a}), 1);

    // R8: exit recovery
    sleep_exit = 1'b1;
    @(negedge clk);
    sleep_exit = 1'b0;
    k = 0;
    while (casl_a) begin k++; @(negedge clk); end
    check(k == SR_EXIT, "R8 exit high time", k, SR_EXIT);
    check(!asl_a && !asl_b, "R8 asleep cleared", int'({asl_a, asl_b}), 0);
    check(req_b == 1'b0, "R9 distributed releases at recovery end", int'(req_b), 0);

    // R10 and R9: resume timing and burst length
    k2 = 0; t_rel = -1;
    while (casl_b) begin
      if (!req_a && t_rel < 0) t_rel = k2;
      k2++;
      @(negedge clk);
    end
    check(k2 == resume_gap(INTERVAL), "R10 first refresh after release", k2, resume_gap(INTERVAL));
    check(t_rel == burst_release(BURST_LEN), "R9 burst release time", t_rel,
          burst_release(BURST_LEN));
    check(mon_a.cbr - base_a == 1 + BURST_LEN, "R9 catch-up burst count",
          mon_a.cbr - base_a, 1 + BURST_LEN);
    check(mon_b.cbr - base_b == 1, "R9 no burst in distributed style", mon_b.cbr - base_b, 1);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule